// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block switches on the supply rails, video drive and backlight of a display panel in a fixed order, and switches them off again in the mirrored order. It runs on the system clock but measures its waits in millisecond ticks, which arrive as single-cycle pulses on `tick_ms`. Raising `pwr_req` starts power-up. Dropping it starts power-down. Enable outputs are a thermometer over five stages: logic supply, analog supply with negative gate supply, positive gate supply, video/logic signals, backlight.

Each wait is a parameter in ticks. It is measured from the cycle the previous step took effect. A tick that coincides with that cycle is not counted, so a wait of N ticks lasts more than N-1 and at most N tick periods. Where the allowed window is bounded on both sides, the target sits near its middle. After every shutdown, and after reset, the rails stay off for a long minimum time before a new power-up may begin.

If power is withdrawn part way through power-up, the steps not yet taken are dropped. Shutdown then runs down from the highest stage that is on.

Top module: `panel_power_sequencer`

## Requirements
- R1: After reset, all five enables are low, `panel_rst_n` is low (reset asserted), and `seq_ready` and `seq_busy` are low.
- R2: Power-up raises the enables one per step, in this order: `rail_logic_en`, `rail_analog_en`, `rail_gate_en`, `video_en`, `bklt_en`. At most one enable changes in any cycle.
- R3: `rail_analog_en` rises 5 ticks after `rail_logic_en` (ANA_DLY). That is more than 0 ms and no more than 10 ms. Counted at the inputs, the gap is 5 or 6 tick pulses. `rail_gate_en` and `bklt_en` each follow the stage before them after 1 tick (1 or 2 pulses).
- R4: `video_en` rises no earlier than 22 ticks after `rail_gate_en` (VIDEO_DLY, 22 or 23 pulses). This keeps the video signals more than 20 ms behind the positive gate supply.
- R5: `panel_rst_n` goes high in the same cycle as `rail_analog_en`, which is at least 4 ms after the logic supply. It goes low again in the same cycle `rail_analog_en` falls.
- R6: Power-down lowers the enables in reverse order: backlight, video, positive gate, analog, logic. Video follows backlight by 1 tick, and gate follows video by 1 tick (1 or 2 pulses each). Logic follows analog by 1 tick.
- R7: `rail_analog_en` falls at least 12 ticks after `rail_gate_en` falls (12 or 13 pulses). This is more than 10 ms.
- R8: `rail_logic_en` cannot rise until 201 ticks (201 or 202 pulses) after it last fell, or after reset is released. This holds even if `pwr_req` is high the whole time.
- R9: If `pwr_req` drops during power-up, no further enable rises. This holds even in the cycle where a step would otherwise complete. Shutdown starts from the highest stage that is on.
- R10: Once shutdown has begun, raising `pwr_req` does not stop it. The block reaches the all-off state, waits the R8 time, and then powers up again.
- R11: `seq_ready` is high only in the steady on state with the backlight lit. `seq_busy` is high during every power-up and power-down transition and low when idle off or steady on. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_req | input | 1 | High requests panel on, low requests panel off |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| rail_logic_en | output | 1 | Enable for the digital logic supply |
| rail_analog_en | output | 1 | Enable for the analog supply and negative gate supply |
| rail_gate_en | output | 1 | Enable for the positive gate supply |
| video_en | output | 1 | Enable for video and control signals |
| bklt_en | output | 1 | Enable for the backlight driver |
| panel_rst_n | output | 1 | Active-low panel reset |
| seq_ready | output | 1 | Panel fully on |
| seq_busy | output | 1 | Transition in progress |

## Verification
The hardest collision is an abort landing on the same clock edge at which the video step's wait completes. Both the abort and the step advance are then eligible at once. The bench counts tick pulses from the rise of the positive gate enable. It drops `pwr_req` in the cycle sampled by the edge just after the 22nd counted tick. It then checks that neither video nor backlight ever rises and that the positive gate supply is the first to fall. The same run also raises the request again mid-shutdown, checking that the shutdown finishes and that the off-time hold is respected before the next power-up.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  // Number of ordered stages: logic, analog, gate, video, backlight
  localparam int unsigned NSTAGE = 5;
  localparam int unsigned LVL_W  = $clog2(NSTAGE + 1);

  typedef enum logic [1:0] {
    M_OFF  = 2'd0,
    M_UP   = 2'd1,
    M_ON   = 2'd2,
    M_DOWN = 2'd3
  } seq_mode_e;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  // A clear wins over a coincident tick; the count saturates at all ones
  assign cnt_en = clr | (tick & ~(&cnt));

  always_comb begin
    if (clr) cnt_n = '0;
    else     cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_n;
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned ANA_DLY       = 5,
  parameter int unsigned GATE_DLY      = 1,
  parameter int unsigned VIDEO_DLY     = 22,
  parameter int unsigned BKLT_DLY      = 1,
  parameter int unsigned VIDEO_OFF_DLY = 1,
  parameter int unsigned GATE_OFF_DLY  = 1,
  parameter int unsigned ANA_OFF_DLY   = 12,
  parameter int unsigned LOGIC_OFF_DLY = 1,
  parameter int unsigned HOLD_TICKS    = 201
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] cnt,
  output logic [LVL_W-1:0] lvl,
  output seq_mode_e        mode,
  output logic             clr
);
  logic [LVL_W-1:0] lvl_n;
  seq_mode_e        mode_n;

  // Wait before raising the next stage, indexed by stages already on
  function automatic logic [CNT_W-1:0] up_wait(input logic [LVL_W-1:0] l);
    if      (l == LVL_W'(1)) return CNT_W'(ANA_DLY);
    else if (l == LVL_W'(2)) return CNT_W'(GATE_DLY);
    else if (l == LVL_W'(3)) return CNT_W'(VIDEO_DLY);
    else                     return CNT_W'(BKLT_DLY);
  endfunction

  // Wait before dropping the top stage, indexed by stages still on
  function automatic logic [CNT_W-1:0] dn_wait(input logic [LVL_W-1:0] l);
    if      (l == LVL_W'(4)) return CNT_W'(VIDEO_OFF_DLY);
    else if (l == LVL_W'(3)) return CNT_W'(GATE_OFF_DLY);
    else if (l == LVL_W'(2)) return CNT_W'(ANA_OFF_DLY);
    else if (l == LVL_W'(1)) return CNT_W'(LOGIC_OFF_DLY);
    else                     return '0;
  endfunction

  always_comb begin
    lvl_n  = lvl;
    mode_n = mode;
    unique case (mode)
      M_OFF: begin
        if (req && (cnt >= CNT_W'(HOLD_TICKS))) begin
          mode_n = M_UP;
          lvl_n  = LVL_W'(1);
        end
      end
      M_UP: begin
        // Withdrawal takes priority over a step that is due
        if (!req) begin
          mode_n = M_DOWN;
        end else if (cnt >= up_wait(lvl)) begin
          lvl_n = lvl + 1'b1;
          if (lvl == LVL_W'(NSTAGE - 1)) mode_n = M_ON;
        end
      end
      M_ON: begin
        if (!req) mode_n = M_DOWN;
      end
      M_DOWN: begin
        if (cnt >= dn_wait(lvl)) begin
          lvl_n = lvl - 1'b1;
          if (lvl == LVL_W'(1)) mode_n = M_OFF;
        end
      end
      default: mode_n = M_OFF;
    endcase
  end

  assign clr = (lvl_n != lvl) || (mode_n != mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl  <= '0;
      mode <= M_OFF;
    end else begin
      lvl  <= lvl_n;
      mode <= mode_n;
    end
  end
endmodule

// File: rtl/pwr_seq_outdec.sv
module pwr_seq_outdec
  import pwr_seq_pkg::*;
#(
  parameter int unsigned RST_STAGE = 2
) (
  input  logic [LVL_W-1:0]  lvl,
  input  seq_mode_e         mode,
  output logic [NSTAGE-1:0] stage_en,
  output logic              rst_rel,
  output logic              ready,
  output logic              busy
);
  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    assign stage_en[g] = (lvl > LVL_W'(g));
  end

  assign rst_rel = (lvl >= LVL_W'(RST_STAGE));
  assign ready   = (mode == M_ON);
  assign busy    = (mode == M_UP) || (mode == M_DOWN);
endmodule

// File: rtl/panel_power_sequencer.sv
module panel_power_sequencer
  import pwr_seq_pkg::*;
#(
  parameter int unsigned ANA_DLY       = 5,
  parameter int unsigned GATE_DLY      = 1,
  parameter int unsigned VIDEO_DLY     = 22,
  parameter int unsigned BKLT_DLY      = 1,
  parameter int unsigned VIDEO_OFF_DLY = 1,
  parameter int unsigned GATE_OFF_DLY  = 1,
  parameter int unsigned ANA_OFF_DLY   = 12,
  parameter int unsigned LOGIC_OFF_DLY = 1,
  parameter int unsigned HOLD_TICKS    = 201
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_req,
  input  logic tick_ms,
  output logic rail_logic_en,
  output logic rail_analog_en,
  output logic rail_gate_en,
  output logic video_en,
  output logic bklt_en,
  output logic panel_rst_n,
  output logic seq_ready,
  output logic seq_busy
);
  localparam int unsigned MAX_A = (HOLD_TICKS > VIDEO_DLY) ? HOLD_TICKS : VIDEO_DLY;
  localparam int unsigned MAX_B = (ANA_OFF_DLY > ANA_DLY) ? ANA_OFF_DLY : ANA_DLY;
  localparam int unsigned MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAX_D + 2);

  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic [CNT_W-1:0]  cnt;
  logic              clr;
  logic [LVL_W-1:0]  lvl;
  seq_mode_e         mode;
  logic [NSTAGE-1:0] stage_en;
  logic              rst_rel;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  pwr_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_i_n),
    .tick  (tick_ms),
    .clr   (clr),
    .cnt   (cnt)
  );

  pwr_seq_ctrl #(
    .CNT_W         (CNT_W),
    .ANA_DLY       (ANA_DLY),
    .GATE_DLY      (GATE_DLY),
    .VIDEO_DLY     (VIDEO_DLY),
    .BKLT_DLY      (BKLT_DLY),
    .VIDEO_OFF_DLY (VIDEO_OFF_DLY),
    .GATE_OFF_DLY  (GATE_OFF_DLY),
    .ANA_OFF_DLY   (ANA_OFF_DLY),
    .LOGIC_OFF_DLY (LOGIC_OFF_DLY),
    .HOLD_TICKS    (HOLD_TICKS)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_i_n),
    .req   (pwr_req),
    .cnt   (cnt),
    .lvl   (lvl),
    .mode  (mode),
    .clr   (clr)
  );

  pwr_seq_outdec #(.RST_STAGE(2)) u_dec (
    .lvl      (lvl),
    .mode     (mode),
    .stage_en (stage_en),
    .rst_rel  (rst_rel),
    .ready    (seq_ready),
    .busy     (seq_busy)
  );

  assign rail_logic_en  = stage_en[0];
  assign rail_analog_en = stage_en[1];
  assign rail_gate_en   = stage_en[2];
  assign video_en       = stage_en[3];
  assign bklt_en        = stage_en[4];
  assign panel_rst_n    = rst_rel;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int unsigned HOLD_TICKS = 201
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_req,
  input logic tick_ms,
  input logic rail_logic_en,
  input logic rail_analog_en,
  input logic rail_gate_en,
  input logic video_en,
  input logic bklt_en,
  input logic panel_rst_n,
  input logic seq_ready,
  input logic seq_busy
);
  logic [4:0]  en_vec;
  int unsigned off_cnt;

  assign en_vec = {bklt_en, video_en, rail_gate_en, rail_analog_en, rail_logic_en};

  // Ticks seen while the logic supply is off, saturating at the hold time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                off_cnt <= 0;
    else if (rail_logic_en)                    off_cnt <= 0;
    else if (tick_ms && off_cnt < HOLD_TICKS)  off_cnt <= off_cnt + 1;
  end

  // R2
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en_vec ^ $past(en_vec)) <= 1);

  // R2
  rise_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rail_gate_en) || $rose(video_en)) |-> $past(rail_analog_en));

  // R6
  fall_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_gate_en) |-> (!video_en && !bklt_en));

  // R5
  panel_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    panel_rst_n |-> (rail_logic_en && rail_analog_en));

  // R8
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_logic_en) |-> (off_cnt >= HOLD_TICKS));

  // R9
  no_rise_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_req |=> !($rose(rail_logic_en) || $rose(rail_analog_en) ||
                   $rose(rail_gate_en) || $rose(video_en) || $rose(bklt_en)));

  // R11
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_ready |-> (bklt_en && !seq_busy));
endmodule

bind panel_power_sequencer pwr_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pwr_req        (pwr_req),
  .tick_ms        (tick_ms),
  .rail_logic_en  (rail_logic_en),
  .rail_analog_en (rail_analog_en),
  .rail_gate_en   (rail_gate_en),
  .video_en       (video_en),
  .bklt_en        (bklt_en),
  .panel_rst_n    (panel_rst_n),
  .seq_ready      (seq_ready),
  .seq_busy       (seq_busy)
);

// File: tb/panel_power_sequencer_tb_top.sv
module panel_power_sequencer_tb_top;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_req = 1'b0;
  logic tick_ms = 1'b0;
  logic rail_logic_en, rail_analog_en, rail_gate_en, video_en, bklt_en;
  logic panel_rst_n, seq_ready, seq_busy;

  always #5 clk = ~clk;

  panel_power_sequencer dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwr_req        (pwr_req),
    .tick_ms        (tick_ms),
    .rail_logic_en  (rail_logic_en),
    .rail_analog_en (rail_analog_en),
    .rail_gate_en   (rail_gate_en),
    .video_en       (video_en),
    .bklt_en        (bklt_en),
    .panel_rst_n    (panel_rst_n),
    .seq_ready      (seq_ready),
    .seq_busy       (seq_busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  int tick_total = 0;
  int cyc = 0;
  int divc = 0;
  logic run_ticks = 1'b0;
  logic finished = 1'b0;
  int rise_t[5], fall_t[5], rise_c[5], fall_c[5], rise_n[5], fall_n[5];
  int rst_rise_c = -1;
  int rst_fall_c = -1;
  logic [4:0] prev_en = '0;
  logic [4:0] cur_en;
  logic prev_rst = 1'b0;

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Edge recorder, tick generator and watchdog, all away from the rising edge
  always @(negedge clk) begin
    cur_en = {bklt_en, video_en, rail_gate_en, rail_analog_en, rail_logic_en};
    for (int i = 0; i < 5; i++) begin
      if (cur_en[i] && !prev_en[i]) begin
        rise_t[i] = tick_total; rise_c[i] = cyc; rise_n[i]++;
      end
      if (!cur_en[i] && prev_en[i]) begin
        fall_t[i] = tick_total; fall_c[i] = cyc; fall_n[i]++;
      end
    end
    if (panel_rst_n && !prev_rst) rst_rise_c = cyc;
    if (!panel_rst_n && prev_rst) rst_fall_c = cyc;
    prev_en  = cur_en;
    prev_rst = panel_rst_n;
    cyc++;
    if (run_ticks) begin
      if (divc == TDIV - 1) begin
        divc = 0; tick_ms = 1'b1; tick_total++;
      end else begin
        divc++; tick_ms = 1'b0;
      end
    end
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: act cycle %0d exp finish before 150000", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act %0d exp %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    chk(act >= lo && act <= hi, tag, act, lo, hi);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_rise(input int i);
    int n0 = rise_n[i];
    while (rise_n[i] == n0) step();
  endtask

  task automatic wait_fall(input int i);
    int n0 = fall_n[i];
    while (fall_n[i] == n0) step();
  endtask

  function automatic int outs();
    return {26'd0, bklt_en, video_en, rail_gate_en, rail_analog_en, rail_logic_en, panel_rst_n};
  endfunction

  // R1: state while reset is held
  task automatic t_reset();
    repeat (3) step();
    chk_rng("R1 enables/panel reset", outs(), 0, 0);
    chk_rng("R1 ready", int'(seq_ready), 0, 0);
    chk_rng("R1 busy", int'(seq_busy), 0, 0);
    rst_n = 1'b1;
    run_ticks = 1'b1;
  endtask

  // R2 R3 R4 R5 R8 R11: power-up with request present from reset
  task automatic t_powerup();
    pwr_req = 1'b1;
    wait_rise(0);
    chk_rng("R8 hold after reset", rise_t[0], 201, 202);
    chk_rng("R11 busy during power-up", int'(seq_busy), 1, 1);
    chk_rng("R11 ready during power-up", int'(seq_ready), 0, 0);
    wait_rise(4);
    chk_rng("R3 logic->analog ticks", rise_t[1] - rise_t[0], 5, 6);
    chk_rng("R3 analog->gate ticks", rise_t[2] - rise_t[1], 1, 2);
    chk_rng("R4 gate->video ticks", rise_t[3] - rise_t[2], 22, 23);
    chk_rng("R3 video->backlight ticks", rise_t[4] - rise_t[3], 1, 2);
    chk(rise_c[0] < rise_c[1] && rise_c[1] < rise_c[2] && rise_c[2] < rise_c[3] && rise_c[3] < rise_c[4],
        "R2 rise order", rise_c[4], rise_c[0], rise_c[4]);
    chk_rng("R5 reset release cycle", rst_rise_c, rise_c[1], rise_c[1]);
    step();
    chk_rng("R11 ready when on", int'(seq_ready), 1, 1);
    chk_rng("R11 busy when on", int'(seq_busy), 0, 0);
  endtask

  // R5 R6 R7 R11: full power-down
  task automatic t_powerdown();
    pwr_req = 1'b0;
    wait_fall(4);
    chk_rng("R11 busy during power-down", int'(seq_busy), 1, 1);
    chk_rng("R11 ready during power-down", int'(seq_ready), 0, 0);
    wait_fall(0);
    chk_rng("R6 backlight->video ticks", fall_t[3] - fall_t[4], 1, 2);
    chk_rng("R6 video->gate ticks", fall_t[2] - fall_t[3], 1, 2);
    chk_rng("R7 gate->analog ticks", fall_t[1] - fall_t[2], 12, 13);
    chk_rng("R6 analog->logic ticks", fall_t[0] - fall_t[1], 1, 2);
    chk_rng("R5 reset assert cycle", rst_fall_c, fall_c[1], fall_c[1]);
    step();
    chk_rng("R6 all off", outs(), 0, 0);
    chk_rng("R11 busy when off", int'(seq_busy), 0, 0);
  endtask

  // R8: immediate re-request after shutdown
  task automatic t_restart();
    pwr_req = 1'b1;
    wait_rise(0);
    chk_rng("R8 off hold ticks", rise_t[0] - fall_t[0], 201, 202);
  endtask

  // R9 R10: abort on the edge the video step completes, re-request mid-shutdown
  task automatic t_abort();
    int vid0 = rise_n[3];
    int bl0  = rise_n[4];
    int lg0;
    int k;
    wait_rise(2);
    k = rise_t[2];
    while (tick_total < k + 22) step();
    step();
    pwr_req = 1'b0;
    wait_fall(2);
    chk_rng("R9 video never rose", rise_n[3] - vid0, 0, 0);
    chk_rng("R9 backlight never rose", rise_n[4] - bl0, 0, 0);
    chk_rng("R9 analog still on at gate fall", int'(rail_analog_en), 1, 1);
    pwr_req = 1'b1;
    lg0 = rise_n[0];
    wait_fall(0);
    chk_rng("R10 gate->analog ticks", fall_t[1] - fall_t[2], 12, 13);
    chk_rng("R10 no restart before off", rise_n[0] - lg0, 0, 0);
    wait_rise(0);
    chk_rng("R10 hold after re-request", rise_t[0] - fall_t[0], 201, 202);
    pwr_req = 1'b0;
    wait_fall(0);
    step();
    chk_rng("R9 all off at end", outs(), 0, 0);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_powerdown();
    t_restart();
    t_abort();
    finished = 1'b1;
    report();
    $finish;
  end
endmodule